// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block produces the status byte that a NOR-style flash memory returns while an internal program or erase algorithm is running. It tracks which operation is in progress, and which sectors are queued for erase. For every read strobe it forms a byte whose flag bits report progress, failure, the state of the erase queuing window, and whether the addressed sector is being erased or is suspended.

Commands arrive as a one-cycle strobe with a 3-bit code, an address and a data byte. The top `SEC_W` bits of any address select its sector. Two single-cycle inputs stand in for the internal algorithm. `opDone` marks normal completion. `limitPulse` marks that the operation ran past its time limit, for example a program into a location that was not blank.

The array itself is not modelled. The only data the block holds is the last programmed byte and its address. Every other array read returns `8'hFF`.

Top module: `flash_status_flags`

## Requirements
- R1: After reset the block is idle, `statusValid` is 0, and a read of any address returns `8'hFF`.
- R2: Each read strobe yields exactly one `statusByte` with `statusValid` high in the following cycle and at no other time. Status bits 4, 1 and 0 are always 0 when the byte is a flag byte.
- R3: Command code 1 (program) is accepted when idle. While programming, bit 7 reads the complement of bit 7 of the written data, bit 6 toggles on every read of any address, bit 3 reads 0 and bit 2 reads 1.
- R4: `opDone` during a program returns the block to idle. A read of the programmed address then returns the written byte, and any other address returns `8'hFF`.
- R5: Command code 2 (sector erase) when idle opens a queuing window of `WIN_CYCLES` cycles. While it is open, bit 3 and bit 7 read 0. A further code 2 adds its sector to the erase set and restarts the full window.
- R6: After the window closes the block is erasing. Bit 3 reads 1 and bit 7 reads 0. Bit 6 toggles on every read. Bit 2 toggles on reads inside the erase set and reads 1 elsewhere. Every command except code 3 (suspend) is ignored.
- R7: A `limitPulse` while programming, erasing or suspend-programming sets bit 5, which stays set. `opDone` is then ignored, and only command code 5 (reset) returns the block to idle and clears the flag. Code 5 has no effect when no failure is flagged.
- R8: Code 3 suspends an erase. In suspend-read mode, a read inside the erase set returns bits 7, 6 and 3 as 1 with bit 2 toggling. A read outside the set returns `8'hFF`. A program aimed at a sector in the set is ignored.
- R9: A program outside the erase set, issued in suspend-read mode, starts a suspend-program. In that mode bit 7 is the data complement, bit 6 toggles, bit 3 is 1, bit 2 reads 1 outside the set and toggles inside it. `opDone` returns the block to suspend-read, and code 4 (resume) returns it to erasing.
- R10: The bit-6 toggle flop restarts at 0 when a program starts, and the bit-2 toggle flop restarts at 0 when an erase starts from idle. The first read after a start shows 0 in the bit that restarted.
- R11: `opDone` while erasing returns the block to idle and empties the erase set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command: 0 none, 1 program, 2 sector erase, 3 suspend, 4 resume, 5 reset |
| cmdAddr | input | ADDR_W | Command address; top SEC_W bits select the sector |
| cmdData | input | 8 | Data byte for a program command |
| opDone | input | 1 | Internal algorithm completed |
| limitPulse | input | 1 | Internal algorithm exceeded its time limit |
| rdStrobe | input | 1 | Status read request |
| rdAddr | input | ADDR_W | Read address |
| statusByte | output | 8 | Status or data byte, valid with statusValid |
| statusValid | output | 1 | statusByte carries the answer to the previous cycle's read |

## Verification
The bench restarts the erase window with a second sector-erase command and then reads after the first window would have expired. A design that does not reload the counter would report bit 3 as 1 there. The bench sends `opDone` after a timing failure and confirms that the block stays busy with bit 5 still set; a design that let completion clear the failure would drop back to data reads. It also aims a program at a suspended sector and reads the erase set again after completion. Each of these catches a design that lets a forbidden command through or keeps stale sectors, which would make bit 2 toggle where it should read 1. The toggle bits are followed read by read across mode changes, so a flop that flips on the wrong reads, or fails to restart at an operation start, shows up as a phase error.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_PROG,
    MODE_WIN,
    MODE_ERASE,
    MODE_SUSP_RD,
    MODE_SUSP_PG
  } modeT;

  localparam logic [2:0] CMD_NOP     = 3'd0;
  localparam logic [2:0] CMD_PROG    = 3'd1;
  localparam logic [2:0] CMD_ERASE   = 3'd2;
  localparam logic [2:0] CMD_SUSPEND = 3'd3;
  localparam logic [2:0] CMD_RESUME  = 3'd4;
  localparam logic [2:0] CMD_RESET   = 3'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadProg;
    logic addSector;
    logic clearSectors;
    logic clr6;
    logic clr2;
    logic flip6;
    logic flip2;
    logic setFail;
    logic clrFail;
    logic loadStatus;
  } strobeT;

endpackage

// File: rtl/fsf_control.sv
module fsf_control
  import fsf_pkg::*;
#(
  parameter int WIN_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       opDone,
  input  logic       limitPulse,
  input  logic       rdStrobe,
  input  logic       rdInSet,
  input  logic       cmdInSet,
  input  logic       failed,
  output modeT       mode,
  output strobeT     strb
);

  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_CYCLES - 1);

  modeT             modeNext;
  logic [CNT_W-1:0] winCnt, winCntNext;

  logic isProg, isErase, isSuspend, isResume, isReset;

  always_comb begin
    isProg    = cmdValid && (cmdCode == CMD_PROG);
    isErase   = cmdValid && (cmdCode == CMD_ERASE);
    isSuspend = cmdValid && (cmdCode == CMD_SUSPEND);
    isResume  = cmdValid && (cmdCode == CMD_RESUME);
    isReset   = cmdValid && (cmdCode == CMD_RESET);
  end

  always_comb begin
    strb       = '0;
    modeNext   = mode;
    winCntNext = winCnt;
    case (mode)
      MODE_IDLE: begin
        if (isProg) begin
          modeNext      = MODE_PROG;
          strb.loadProg = 1'b1;
          strb.clr6     = 1'b1;
        end else if (isErase) begin
          modeNext       = MODE_WIN;
          strb.addSector = 1'b1;
          strb.clr6      = 1'b1;
          strb.clr2      = 1'b1;
          winCntNext     = WIN_LAST;
        end
      end
      MODE_PROG: begin
        if (failed) begin
          if (isReset) begin
            modeNext     = MODE_IDLE;
            strb.clrFail = 1'b1;
          end
        end else if (opDone) begin
          modeNext = MODE_IDLE;
        end
      end
      MODE_WIN: begin
        if (isErase) begin
          strb.addSector = 1'b1;
          winCntNext     = WIN_LAST;
        end else if (winCnt == '0) begin
          modeNext = MODE_ERASE;
        end else begin
          winCntNext = winCnt - 1'b1;
        end
      end
      MODE_ERASE: begin
        if (failed) begin
          if (isReset) begin
            modeNext          = MODE_IDLE;
            strb.clrFail      = 1'b1;
            strb.clearSectors = 1'b1;
          end
        end else if (opDone) begin
          modeNext          = MODE_IDLE;
          strb.clearSectors = 1'b1;
        end else if (isSuspend) begin
          modeNext = MODE_SUSP_RD;
        end
      end
      MODE_SUSP_RD: begin
        if (isProg && !cmdInSet) begin
          modeNext      = MODE_SUSP_PG;
          strb.loadProg = 1'b1;
          strb.clr6     = 1'b1;
        end else if (isResume) begin
          modeNext = MODE_ERASE;
        end
      end
      MODE_SUSP_PG: begin
        if (failed) begin
          if (isReset) begin
            modeNext          = MODE_IDLE;
            strb.clrFail      = 1'b1;
            strb.clearSectors = 1'b1;
          end
        end else if (opDone) begin
          modeNext = MODE_SUSP_RD;
        end
      end
      default: modeNext = MODE_IDLE;
    endcase

    strb.setFail    = limitPulse &&
                      (mode inside {MODE_PROG, MODE_ERASE, MODE_SUSP_PG});
    strb.flip6      = rdStrobe &&
                      (mode inside {MODE_PROG, MODE_WIN, MODE_ERASE, MODE_SUSP_PG});
    strb.flip2      = rdStrobe && rdInSet &&
                      (mode inside {MODE_WIN, MODE_ERASE, MODE_SUSP_RD, MODE_SUSP_PG});
    strb.loadStatus = rdStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode   <= MODE_IDLE;
      winCnt <= '0;
    end else begin
      mode   <= modeNext;
      winCnt <= winCntNext;
    end
  end

endmodule

// File: rtl/fsf_datapath.sv
module fsf_datapath
  import fsf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEC_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  modeT              mode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdInSet,
  output logic              cmdInSet,
  output logic              failed,
  output logic [7:0]        statusByte,
  output logic              statusValid
);

  localparam int NUM_SEC = 1 << SEC_W;

  logic [NUM_SEC-1:0] sectorSet;
  logic [ADDR_W-1:0]  progAddr;
  logic [7:0]         progData;
  logic               tog6, tog2;
  logic [SEC_W-1:0]   rdSec, cmdSec;
  logic [7:0]         statusNext;
  logic               dq2Sel;

  always_comb begin
    rdSec    = rdAddr[ADDR_W-1 -: SEC_W];
    cmdSec   = cmdAddr[ADDR_W-1 -: SEC_W];
    rdInSet  = sectorSet[rdSec];
    cmdInSet = sectorSet[cmdSec];
    dq2Sel   = rdInSet ? tog2 : 1'b1;
  end

  always_comb begin
    case (mode)
      MODE_IDLE:    statusNext = (rdAddr == progAddr) ? progData : 8'hFF;
      MODE_PROG:    statusNext = {~progData[7], tog6, failed, 1'b0, 1'b0, 1'b1, 2'b00};
      MODE_WIN:     statusNext = {1'b0, tog6, 1'b0, 1'b0, 1'b0, dq2Sel, 2'b00};
      MODE_ERASE:   statusNext = {1'b0, tog6, failed, 1'b0, 1'b1, dq2Sel, 2'b00};
      MODE_SUSP_RD: statusNext = rdInSet ? {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, tog2, 2'b00}
                                         : 8'hFF;
      MODE_SUSP_PG: statusNext = {~progData[7], tog6, failed, 1'b0, 1'b1, dq2Sel, 2'b00};
      default:      statusNext = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectorSet   <= '0;
      progAddr    <= '0;
      progData    <= 8'hFF;
      tog6        <= 1'b0;
      tog2        <= 1'b0;
      failed      <= 1'b0;
      statusByte  <= 8'h00;
      statusValid <= 1'b0;
    end else begin
      if (strb.clearSectors)   sectorSet <= '0;
      else if (strb.addSector) sectorSet[cmdSec] <= 1'b1;

      if (strb.loadProg) begin
        progAddr <= cmdAddr;
        progData <= cmdData;
      end

      if (strb.clr6)       tog6 <= 1'b0;
      else if (strb.flip6) tog6 <= ~tog6;

      if (strb.clr2)       tog2 <= 1'b0;
      else if (strb.flip2) tog2 <= ~tog2;

      if (strb.clrFail)      failed <= 1'b0;
      else if (strb.setFail) failed <= 1'b1;

      statusValid <= strb.loadStatus;
      if (strb.loadStatus) statusByte <= statusNext;
    end
  end

endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags
  import fsf_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SEC_W      = 3,
  parameter int WIN_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              opDone,
  input  logic              limitPulse,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        statusByte,
  output logic              statusValid
);

  modeT   mode;
  strobeT strb;
  logic   rdInSet, cmdInSet, failed;

  fsf_control #(
    .WIN_CYCLES(WIN_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode),
    .opDone    (opDone),
    .limitPulse(limitPulse),
    .rdStrobe  (rdStrobe),
    .rdInSet   (rdInSet),
    .cmdInSet  (cmdInSet),
    .failed    (failed),
    .mode      (mode),
    .strb      (strb)
  );

  fsf_datapath #(
    .ADDR_W(ADDR_W),
    .SEC_W (SEC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .mode       (mode),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .rdAddr     (rdAddr),
    .rdInSet    (rdInSet),
    .cmdInSet   (cmdInSet),
    .failed     (failed),
    .statusByte (statusByte),
    .statusValid(statusValid)
  );

endmodule

// File: rtl/fsf_checker.sv
module fsf_checker
  import fsf_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdCode,
  input logic       opDone,
  input logic       rdStrobe,
  input logic       statusValid,
  input logic [7:0] statusByte,
  input modeT       mode,
  input logic       failed
);

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> statusValid);  // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> !statusValid);  // R2

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (failed && !(cmdValid && cmdCode == CMD_RESET)) |=> failed);  // R7

  AST_FAIL_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (failed && !(cmdValid && cmdCode == CMD_RESET)) |=> (mode != MODE_IDLE));  // R7

  AST_ERASE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ERASE && !opDone &&
     !(cmdValid && (cmdCode == CMD_SUSPEND || cmdCode == CMD_RESET)))
    |=> (mode == MODE_ERASE));  // R6

  AST_WIN_DQ3_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && mode == MODE_WIN) |=> (!statusByte[3] && !statusByte[7]));  // R5

  AST_ERASE_DQ3_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && mode == MODE_ERASE) |=> (statusByte[3] && !statusByte[7]));  // R6

  AST_SUSP_DQ6_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && mode == MODE_SUSP_RD) |=> statusByte[6]);  // R8

endmodule

bind flash_status_flags fsf_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdCode    (cmdCode),
  .opDone     (opDone),
  .rdStrobe   (rdStrobe),
  .statusValid(statusValid),
  .statusByte (statusByte),
  .mode       (mode),
  .failed     (failed)
);

// File: tb/tb_flash_status_flags.sv
module tb_flash_status_flags;
  import fsf_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = CMD_NOP;
  logic [7:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic       opDone = 1'b0;
  logic       limitPulse = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] statusByte;
  logic       statusValid;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       t6, t2;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_flags dut (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .opDone     (opDone),
    .limitPulse (limitPulse),
    .rdStrobe   (rdStrobe),
    .rdAddr     (rdAddr),
    .statusByte (statusByte),
    .statusValid(statusValid)
  );

  function automatic logic [7:0] pk(logic d7, logic d6, logic d5, logic d3, logic d2);
    return {d7, d6, d5, 1'b0, d3, d2, 2'b00};
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per valid status byte
  always @(negedge clk) begin
    if (rstN && statusValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected valid", statusByte, 8'h00);
      end else begin
        logic [7:0] e;
        string      tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        check(statusByte === e, tg, statusByte, e);
      end
    end
  end

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    rdStrobe = 1'b1;
    rdAddr   = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic sendCmd(logic [2:0] code, logic [7:0] a, logic [7:0] d);
    cmdValid = 1'b1;
    cmdCode  = code;
    cmdAddr  = a;
    cmdData  = d;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = CMD_NOP;
  endtask

  task automatic pulseDone();
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
  endtask

  task automatic pulseLimit();
    limitPulse = 1'b1;
    @(negedge clk);
    limitPulse = 1'b0;
  endtask

  task automatic finish();
    if (expQ.size() != 0) check(1'b0, "R2 missing status bytes", 8'(expQ.size()), 8'h00);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R2 watchdog expired", 8'h00, 8'h01);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    t6 = 1'b0;
    t2 = 1'b0;
    repeat (3) @(negedge clk);
    check(statusValid == 1'b0, "R1 valid low in reset", {7'b0, statusValid}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check(statusValid == 1'b0, "R1 valid low after reset", {7'b0, statusValid}, 8'h00);
    rd(8'h00, 8'hFF, "R1 idle read");

    // Program, data bit 7 = 1
    sendCmd(CMD_PROG, 8'h12, 8'hA5); t6 = 1'b0;
    rd(8'h12, pk(0, t6, 0, 0, 1), "R10 first read after program start"); t6 = ~t6;
    rd(8'h77, pk(0, t6, 0, 0, 1), "R3 toggle any address"); t6 = ~t6;
    rd(8'hE0, pk(0, t6, 0, 0, 1), "R3 toggle again"); t6 = ~t6;
    pulseDone();
    rd(8'h12, 8'hA5, "R4 programmed data");
    rd(8'h13, 8'hFF, "R4 other address");

    // Program, data bit 7 = 0, then timing failure
    sendCmd(CMD_PROG, 8'h30, 8'h3C); t6 = 1'b0;
    rd(8'h30, pk(1, t6, 0, 0, 1), "R3 complement of bit 7"); t6 = ~t6;
    sendCmd(CMD_RESET, 8'h00, 8'h00);
    rd(8'h30, pk(1, t6, 0, 0, 1), "R7 reset ignored without failure"); t6 = ~t6;
    pulseLimit();
    rd(8'h30, pk(1, t6, 1, 0, 1), "R7 failure flag set"); t6 = ~t6;
    pulseDone();
    rd(8'h30, pk(1, t6, 1, 0, 1), "R7 done ignored after failure"); t6 = ~t6;
    sendCmd(CMD_RESET, 8'h00, 8'h00);
    rd(8'h30, 8'h3C, "R7 reset returns to idle");

    // Sector erase with window restart
    sendCmd(CMD_ERASE, 8'h40, 8'h00); t6 = 1'b0; t2 = 1'b0;
    rd(8'h45, pk(0, t6, 0, 0, t2), "R5 window in-set read"); t6 = ~t6; t2 = ~t2;
    rd(8'h05, pk(0, t6, 0, 0, 1), "R5 window out-of-set read"); t6 = ~t6;
    repeat (8) @(negedge clk);
    sendCmd(CMD_ERASE, 8'h80, 8'h00);
    repeat (10) @(negedge clk);
    rd(8'h85, pk(0, t6, 0, 0, t2), "R5 window restarted by second erase"); t6 = ~t6; t2 = ~t2;
    repeat (20) @(negedge clk);
    rd(8'h45, pk(0, t6, 0, 1, t2), "R6 erasing in-set read"); t6 = ~t6; t2 = ~t2;
    sendCmd(CMD_PROG, 8'h10, 8'h00);
    rd(8'h10, pk(0, t6, 0, 1, 1), "R6 program ignored while erasing"); t6 = ~t6;

    // Suspend
    sendCmd(CMD_SUSPEND, 8'h00, 8'h00);
    rd(8'h45, pk(1, 1, 0, 1, t2), "R8 suspended sector read"); t2 = ~t2;
    rd(8'h86, pk(1, 1, 0, 1, t2), "R8 second suspended sector"); t2 = ~t2;
    rd(8'h10, 8'hFF, "R8 outside set");
    sendCmd(CMD_PROG, 8'h46, 8'h00);
    rd(8'h45, pk(1, 1, 0, 1, t2), "R8 program into set ignored"); t2 = ~t2;

    // Suspend program
    sendCmd(CMD_PROG, 8'h10, 8'h80); t6 = 1'b0;
    rd(8'h10, pk(0, t6, 0, 1, 1), "R9 program address read"); t6 = ~t6;
    rd(8'h85, pk(0, t6, 0, 1, t2), "R9 suspended sector read"); t6 = ~t6; t2 = ~t2;
    pulseDone();
    rd(8'h45, pk(1, 1, 0, 1, t2), "R9 back to suspend read"); t2 = ~t2;
    sendCmd(CMD_RESUME, 8'h00, 8'h00);
    rd(8'h45, pk(0, t6, 0, 1, t2), "R9 resume erasing"); t6 = ~t6; t2 = ~t2;
    pulseDone();
    rd(8'h10, 8'h80, "R11 idle after erase");
    rd(8'h45, 8'hFF, "R11 idle other address");

    // New erase: old sectors gone, toggle restarts
    sendCmd(CMD_ERASE, 8'h20, 8'h00); t6 = 1'b0; t2 = 1'b0;
    rd(8'h85, pk(0, t6, 0, 0, 1), "R11 old sector dropped"); t6 = ~t6;
    rd(8'h25, pk(0, t6, 0, 0, t2), "R10 bit 2 restarts"); t6 = ~t6; t2 = ~t2;
    repeat (3) @(negedge clk);
    finish();
  end

endmodule